// File: doc/BRIEF.md
# I2C Bus Control and Direction Tracker

This block is the control core of an I2C controller. It watches the synchronized SCL and SDA lines, recognises START and STOP conditions, and keeps a bus-busy flag from them. It decodes a four-field control write into a request for a START followed by the address byte, or a request for a STOP. It passes each request to a separate bit engine as a single-cycle pulse. The bit engine does the byte shifting and generates the clock rate; neither is part of this block.

The block also keeps the master and transmitter flags. When the bit engine reports that an address byte has finished, the block sets the transmitter flag from the direction bit. In slave mode the flag follows the direction bit of a matching address or a general call. In master mode it takes the inverse of the direction bit sent, but only when the slave acknowledged. A STOP on the bus or a lost arbitration clears the flag.

The control word has four bits: bit 3 is master, bit 2 is transmit, bit 1 is busy and bit 0 is pin. An address byte carries the 7-bit address in bits 7..1 and the direction bit in bit 0.

Top module: `i2cctl_core`

## Requirements
- R1: A START (SDA falls while SCL is high) sets busy_o on the third rising clock edge after the SDA change reaches the pins. busy_o is still 0 after the second edge.
- R2: A STOP (SDA rises while SCL is high) clears busy_o with the same three-edge latency.
- R3: busy_o follows only bus conditions. A control write never changes it, whatever the busy bit of the word holds.
- R4: A write of 4'b1111 while busy_o is 0 gives start_req_o high for exactly the one cycle after the write. It also loads mst_o=1 and trx_o=1.
- R5: A write of 4'b1101 (master=1, transmit=1, busy=0, pin=1) while busy_o is 1 gives stop_req_o high for exactly the one cycle after the write.
- R6: Once a STOP has been requested, every control write is ignored until a STOP is detected on the bus. mst_o and trx_o are left unchanged and no request pulse is produced. The first write after that STOP is accepted.
- R7: In slave mode (mst_o=0), when an address byte completes and bits 7..1 equal own_addr_i, trx_o takes the value of bit 0.
- R8: In slave mode, an all-zero address byte (general call) clears trx_o. A byte that does not match leaves trx_o unchanged.
- R9: In master mode (mst_o=1), when an address byte completes with ack_i=1, trx_o takes the inverse of bit 0.
- R10: In master mode, when an address byte completes with ack_i=0, trx_o keeps its value.
- R11: A detected STOP or a pulse on arb_lost_i clears trx_o on the next edge. This takes priority over any other update in the same cycle.
- R12: Outside the request patterns, a write that is accepted loads only mst_o and trx_o from bits 3 and 2. 4'b1111 with busy_o=1 produces no start_req_o, and 4'b1101 with busy_o=0 produces no stop_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| own_addr_i | input | 7 | Own slave address |
| addr_byte_i | input | 8 | Address byte received or sent, direction in bit 0 |
| addr_done_i | input | 1 | One-cycle pulse from the bit engine when the address byte and its acknowledge slot are complete |
| ack_i | input | 1 | Acknowledge seen for the address byte |
| arb_lost_i | input | 1 | Arbitration-lost pulse from the bit engine |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_data_i | input | 4 | Control word {master, transmit, busy, pin} |
| busy_o | output | 1 | Bus busy flag |
| trx_o | output | 1 | Transmitter flag |
| mst_o | output | 1 | Master flag |
| start_req_o | output | 1 | One-cycle START-plus-address request |
| stop_req_o | output | 1 | One-cycle STOP request |

## Verification
Results from control writes, address-byte completions and arbitration loss are registered once, so they are due one edge after the input pulse. A line event passes through two synchronizer stages and one flag register, so it is due on the third edge. The bench drives every input on a falling edge and counts the exact rising edges to the result. It samples on the falling edge where the value is due. For bus conditions it also checks one edge earlier that busy_o has not yet moved, so a change in latency is caught. For request pulses it samples the cycle after the write and the cycle after that, which confirms that the pulse lasts exactly one cycle.

// File: rtl/i2cctl_pkg.sv
package i2cctl_pkg;

    // Control word layout: {master, transmit, busy, pin}
    typedef struct packed {
        logic mst;
        logic trx;
        logic bb;
        logic pin;
    } ctl_word_t;

    localparam logic [3:0] START_PAT = 4'b1111;
    localparam logic [3:0] STOP_PAT  = 4'b1101;

    typedef enum logic [1:0] {
        COND_NONE  = 2'd0,
        COND_START = 2'd1,
        COND_STOP  = 2'd2
    } bus_cond_e;

endpackage

// File: rtl/i2cctl_sync.sv
module i2cctl_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] out_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_d[g] = in_i;
        end else begin : g_next
            assign stage_d[g] = stage_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2cctl_busmon.sv
module i2cctl_busmon
    import i2cctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det_o,
    output logic stop_det_o,
    output logic busy_o
);
    typedef struct packed {
        logic sda_prev;
        logic busy;
    } mon_t;

    mon_t      mon_d, mon_q;
    bus_cond_e cond;

    always_comb begin
        cond = COND_NONE;
        if (scl_s && mon_q.sda_prev && !sda_s) begin
            cond = COND_START;
        end else if (scl_s && !mon_q.sda_prev && sda_s) begin
            cond = COND_STOP;
        end

        mon_d          = mon_q;
        mon_d.sda_prev = sda_s;
        case (cond)
            COND_START: mon_d.busy = 1'b1;
            COND_STOP:  mon_d.busy = 1'b0;
            default:    mon_d.busy = mon_q.busy;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '{sda_prev: 1'b1, busy: 1'b0};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign start_det_o = (cond == COND_START);
    assign stop_det_o  = (cond == COND_STOP);
    assign busy_o      = mon_q.busy;
endmodule

// File: rtl/i2cctl_cmd.sv
module i2cctl_cmd
    import i2cctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr_i,
    input  ctl_word_t ctl_i,
    input  logic      busy_i,
    input  logic      stop_det_i,
    output logic      wr_acc_o,
    output logic      start_req_o,
    output logic      stop_req_o,
    output logic      stop_pend_o
);
    typedef struct packed {
        logic start;
        logic stop;
        logic pend;
    } cmd_t;

    cmd_t cmd_d, cmd_q;
    logic wr_acc;

    always_comb begin
        // A pending STOP locks out the control fields
        wr_acc      = ctl_wr_i && !cmd_q.pend;
        cmd_d       = cmd_q;
        cmd_d.start = wr_acc && !busy_i && (ctl_i == START_PAT);
        cmd_d.stop  = wr_acc &&  busy_i && (ctl_i == STOP_PAT);
        if (stop_det_i) begin
            cmd_d.pend = 1'b0;
        end
        if (cmd_d.stop) begin
            cmd_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign wr_acc_o    = wr_acc;
    assign start_req_o = cmd_q.start;
    assign stop_req_o  = cmd_q.stop;
    assign stop_pend_o = cmd_q.pend;
endmodule

// File: rtl/i2cctl_dir.sv
module i2cctl_dir
    import i2cctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc_i,
    input  ctl_word_t         ctl_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [BYTE_W-1:0] addr_byte_i,
    input  logic              addr_done_i,
    input  logic              ack_i,
    input  logic              arb_lost_i,
    input  logic              stop_det_i,
    output logic              mst_o,
    output logic              trx_o
);
    typedef struct packed {
        logic mst;
        logic trx;
    } dir_t;

    dir_t dir_d, dir_q;
    logic dir_bit;
    logic addr_hit;
    logic gen_call;

    always_comb begin
        dir_bit  = addr_byte_i[0];
        addr_hit = (addr_byte_i[BYTE_W-1:1] == own_addr_i);
        gen_call = (addr_byte_i == '0);

        dir_d = dir_q;
        if (wr_acc_i) begin
            dir_d.mst = ctl_i.mst;
            dir_d.trx = ctl_i.trx;
        end
        if (addr_done_i) begin
            if (dir_q.mst) begin
                if (ack_i) begin
                    dir_d.trx = !dir_bit;
                end
            end else if (addr_hit || gen_call) begin
                dir_d.trx = dir_bit;
            end
        end
        if (stop_det_i || arb_lost_i) begin
            dir_d.trx = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            dir_q <= dir_d;
        end
    end

    assign mst_o = dir_q.mst;
    assign trx_o = dir_q.trx;
endmodule

// File: rtl/i2cctl_core.sv
module i2cctl_core
    import i2cctl_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [BYTE_W-1:0] addr_byte_i,
    input  logic              addr_done_i,
    input  logic              ack_i,
    input  logic              arb_lost_i,
    input  logic              ctl_wr_i,
    input  logic [3:0]        ctl_data_i,
    output logic              busy_o,
    output logic              trx_o,
    output logic              mst_o,
    output logic              start_req_o,
    output logic              stop_req_o
);
    logic [1:0] line_s;
    logic       start_det;
    logic       stop_det;
    logic       stop_pend;
    logic       wr_acc;
    ctl_word_t  ctl_word;

    assign ctl_word = ctl_word_t'(ctl_data_i);

    i2cctl_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .in_i ({scl_i, sda_i}),
        .out_o(line_s)
    );

    i2cctl_busmon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (line_s[1]),
        .sda_s      (line_s[0]),
        .start_det_o(start_det),
        .stop_det_o (stop_det),
        .busy_o     (busy_o)
    );

    i2cctl_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr_i   (ctl_wr_i),
        .ctl_i      (ctl_word),
        .busy_i     (busy_o),
        .stop_det_i (stop_det),
        .wr_acc_o   (wr_acc),
        .start_req_o(start_req_o),
        .stop_req_o (stop_req_o),
        .stop_pend_o(stop_pend)
    );

    i2cctl_dir #(
        .ADDR_W(ADDR_W)
    ) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc_i   (wr_acc),
        .ctl_i      (ctl_word),
        .own_addr_i (own_addr_i),
        .addr_byte_i(addr_byte_i),
        .addr_done_i(addr_done_i),
        .ack_i      (ack_i),
        .arb_lost_i (arb_lost_i),
        .stop_det_i (stop_det),
        .mst_o      (mst_o),
        .trx_o      (trx_o)
    );
endmodule

// File: rtl/i2cctl_core_chk.sv
module i2cctl_core_chk #(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] own_addr_i,
    input logic [BYTE_W-1:0] addr_byte_i,
    input logic              addr_done_i,
    input logic              ack_i,
    input logic              arb_lost_i,
    input logic              ctl_wr_i,
    input logic [3:0]        ctl_data_i,
    input logic              busy_o,
    input logic              trx_o,
    input logic              mst_o,
    input logic              start_req_o,
    input logic              stop_req_o,
    input logic              start_det,
    input logic              stop_det,
    input logic              stop_pend
);
    // R1
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy_o);

    // R2
    busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy_o);

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !stop_det) |=> $stable(busy_o));

    // R4
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req_o |-> $past(ctl_wr_i && !busy_o && ctl_data_i == 4'b1111));

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req_o |=> !start_req_o);

    // R5
    stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req_o |-> $past(ctl_wr_i && busy_o && ctl_data_i == 4'b1101));

    // R6
    pend_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend && ctl_wr_i) |=> ($stable(mst_o) && !start_req_o && !stop_req_o));

    // R7
    slave_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_o && addr_done_i && addr_byte_i[BYTE_W-1:1] == own_addr_i
         && !arb_lost_i && !stop_det) |=> (trx_o == $past(addr_byte_i[0])));

    // R9
    master_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_o && addr_done_i && ack_i && !arb_lost_i && !stop_det)
        |=> (trx_o == !$past(addr_byte_i[0])));

    // R11
    trx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost_i || stop_det) |=> !trx_o);
endmodule

bind i2cctl_core i2cctl_core_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/i2cctl_core_test.sv
`timescale 1ns/1ps
module i2cctl_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_i = 1'b1;
    logic       sda_i = 1'b1;
    logic [6:0] own_addr_i = 7'h35;
    logic [7:0] addr_byte_i = 8'h00;
    logic       addr_done_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       arb_lost_i = 1'b0;
    logic       ctl_wr_i = 1'b0;
    logic [3:0] ctl_data_i = 4'h0;
    logic       busy_o, trx_o, mst_o, start_req_o, stop_req_o;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    i2cctl_core uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .own_addr_i(own_addr_i), .addr_byte_i(addr_byte_i),
        .addr_done_i(addr_done_i), .ack_i(ack_i), .arb_lost_i(arb_lost_i),
        .ctl_wr_i(ctl_wr_i), .ctl_data_i(ctl_data_i),
        .busy_o(busy_o), .trx_o(trx_o), .mst_o(mst_o),
        .start_req_o(start_req_o), .stop_req_o(stop_req_o)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Drive a write at a falling edge; sample the pulse one edge later, then its end
    task automatic ctl_write(input logic [3:0] w, output logic st, output logic sp,
                             output logic st2, output logic sp2);
        @(negedge clk);
        ctl_wr_i = 1'b1; ctl_data_i = w;
        @(negedge clk);
        st = start_req_o; sp = stop_req_o;
        ctl_wr_i = 1'b0;
        @(negedge clk);
        st2 = start_req_o; sp2 = stop_req_o;
    endtask

    task automatic addr_phase(input logic [7:0] b, input logic ack);
        @(negedge clk);
        addr_byte_i = b; ack_i = ack; addr_done_i = 1'b1;
        @(negedge clk);
        addr_done_i = 1'b0;
    endtask

    // Change one line and check busy moves on the third edge, not the second
    task automatic line_event(input bit is_sda, input logic v, input string tag,
                              input logic busy_exp, input logic busy_before);
        @(negedge clk);
        if (is_sda) sda_i = v; else scl_i = v;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk(tag, "busy after 2 edges", busy_o, busy_before);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "busy after 3 edges", busy_o, busy_exp);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("reset", "busy", busy_o, 1'b0);
        chk("reset", "trx", trx_o, 1'b0);
        chk("reset", "mst", mst_o, 1'b0);
        chk("reset", "start_req", start_req_o, 1'b0);
        chk("reset", "stop_req", stop_req_o, 1'b0);
    endtask

    task automatic t_idle_writes();
        logic st, sp, st2, sp2;
        // R3: busy field written 1 on an idle bus
        ctl_write(4'b0010, st, sp, st2, sp2);
        chk("R3", "busy after bb=1 write", busy_o, 1'b0);
        chk("R3", "no start", st, 1'b0);
        // R12: stop pattern on idle bus only loads fields
        ctl_write(4'b1101, st, sp, st2, sp2);
        chk("R12", "no stop when idle", sp, 1'b0);
        chk("R12", "mst loaded", mst_o, 1'b1);
        chk("R12", "trx loaded", trx_o, 1'b1);
        ctl_write(4'b0000, st, sp, st2, sp2);
        chk("R12", "mst cleared by write", mst_o, 1'b0);
    endtask

    task automatic t_start_req();
        logic st, sp, st2, sp2;
        ctl_write(4'b1111, st, sp, st2, sp2);
        chk("R4", "start pulse", st, 1'b1);
        chk("R4", "start pulse ends", st2, 1'b0);
        chk("R4", "mst", mst_o, 1'b1);
        chk("R4", "trx", trx_o, 1'b1);
        chk("R4", "no stop", sp, 1'b0);
    endtask

    task automatic t_master_addr();
        addr_phase({7'h2A, 1'b1}, 1'b1);
        chk("R9", "read addr acked", trx_o, 1'b0);
        addr_phase({7'h2A, 1'b0}, 1'b1);
        chk("R9", "write addr acked", trx_o, 1'b1);
        addr_phase({7'h2A, 1'b1}, 1'b0);
        chk("R10", "no ack keeps trx", trx_o, 1'b1);
    endtask

    task automatic t_busy_writes();
        logic st, sp, st2, sp2;
        ctl_write(4'b1111, st, sp, st2, sp2);
        chk("R12", "no start while busy", st, 1'b0);
        ctl_write(4'b1100, st, sp, st2, sp2);
        chk("R3", "busy kept with bb=0", busy_o, 1'b1);
        chk("R3", "pin=0 not a stop", sp, 1'b0);
    endtask

    task automatic t_stop_req();
        logic st, sp, st2, sp2;
        ctl_write(4'b1101, st, sp, st2, sp2);
        chk("R5", "stop pulse", sp, 1'b1);
        chk("R5", "stop pulse ends", sp2, 1'b0);
        // R6: locked until bus STOP
        ctl_write(4'b0000, st, sp, st2, sp2);
        chk("R6", "mst held", mst_o, 1'b1);
        chk("R6", "trx held", trx_o, 1'b1);
        ctl_write(4'b1101, st, sp, st2, sp2);
        chk("R6", "no repeat stop", sp, 1'b0);
    endtask

    task automatic t_bus_stop();
        logic st, sp, st2, sp2;
        line_event(1'b0, 1'b0, "R2", 1'b1, 1'b1);
        line_event(1'b0, 1'b1, "R2", 1'b1, 1'b1);
        line_event(1'b1, 1'b1, "R2", 1'b0, 1'b1);
        chk("R11", "stop clears trx", trx_o, 1'b0);
        ctl_write(4'b0000, st, sp, st2, sp2);
        chk("R6", "write accepted after stop", mst_o, 1'b0);
    endtask

    task automatic t_slave();
        addr_phase({7'h35, 1'b1}, 1'b1);
        chk("R7", "match read", trx_o, 1'b1);
        addr_phase({7'h35, 1'b0}, 1'b0);
        chk("R7", "match write", trx_o, 1'b0);
        addr_phase({7'h35, 1'b1}, 1'b0);
        addr_phase({7'h12, 1'b0}, 1'b1);
        chk("R8", "mismatch keeps trx", trx_o, 1'b1);
        addr_phase(8'h00, 1'b1);
        chk("R8", "general call", trx_o, 1'b0);
        addr_phase({7'h35, 1'b1}, 1'b0);
        @(negedge clk);
        arb_lost_i = 1'b1;
        @(negedge clk);
        arb_lost_i = 1'b0;
        chk("R11", "arbitration lost clears trx", trx_o, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_writes();
        t_start_req();
        line_event(1'b1, 1'b0, "R1", 1'b1, 1'b0);
        t_master_addr();
        t_busy_writes();
        t_stop_req();
        t_bus_stop();
        line_event(1'b1, 1'b0, "R1", 1'b1, 1'b0);
        t_slave();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule